// File: doc/BRIEF.md
# SPD Write-Protect and Page Controller

This block holds the write-protection and page-selection state for a 512-byte serial presence-detect memory. The memory is viewed as two 256-byte pages, each split into two 128-byte halves, which gives four protectable blocks. A 2-wire slave front end decodes the bus traffic and hands this block one command at a time: an opcode, a block index and a flag that says the high-voltage condition is present on the select pin. For every accepted command the block returns a single acknowledge or no-acknowledge decision. Protection and page status leave the block only through that decision.

The front end also presents the word address of each normal byte write. The block answers at once with a write-permit flag. The block index for that check is the current page bit followed by the top bit of the word address. Protection can be set one block at a time, but it can only be cleared for all four blocks together, and only while the high-voltage flag is present. The four protect bits load from an init input during reset, which stands in for the nonvolatile copy. The page bit always resets to page 0.

Commands use a valid/ready handshake, and so do responses. A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. Its response appears in the next cycle and stays unchanged until `rsp_ready` is seen. `cmd_ready` drops only while an earlier response is still waiting, so back-pressure on the response channel stalls the command channel.

Top module: `spd_guard`

## Requirements
- R1: During reset the protect bits take the value of `prot_init` (bit n is block n). The page bit goes to 0 and no response is pending.
- R2: `wr_ok` is 0 when the block at index {page, wr_addr[7]} is protected and 1 otherwise. Block 0 is page 0 below 80h, block 1 is page 0 from 80h, block 2 is page 1 below 80h, block 3 is page 1 from 80h.
- R3: Set-protect (opcode 0) with `cmd_hv` high protects only block `cmd_blk` and is acknowledged.
- R4: Clear-protect (opcode 1) with `cmd_hv` high unprotects all four blocks and is acknowledged.
- R5: Set-protect or clear-protect with `cmd_hv` low is not acknowledged and leaves every protect bit unchanged, as `wr_ok` shows.
- R6: Protect query (opcode 2) acknowledges if block `cmd_blk` is unprotected and withholds the acknowledge if it is protected. State is not changed.
- R7: Select-page-0 (opcode 3) and select-page-1 (opcode 4) set the page bit and are acknowledged whatever the level of `cmd_hv`.
- R8: Page query (opcode 5) acknowledges when the page bit is 0 and withholds the acknowledge when it is 1.
- R9: Opcodes 6 and 7 are not acknowledged and change no state.
- R10: A response is valid in the cycle after its command is accepted. It holds `rsp_ack` stable until `rsp_ready` is high. `cmd_ready` equals (not `rsp_valid`) or `rsp_ready`.
- R11: A state change from an accepted command shows on `wr_ok` in the next cycle, and a query sees the state left by every earlier command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prot_init | input | 4 | Protect bits loaded during reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | 3 | Command opcode |
| cmd_blk | input | 2 | Block index for protect commands |
| cmd_hv | input | 1 | High-voltage condition present |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_ack | output | 1 | 1 = acknowledge, 0 = no acknowledge |
| wr_addr | input | 8 | Word address of a normal byte write |
| wr_ok | output | 1 | Write to wr_addr is permitted |

## Verification
The assertions check on every cycle that a response is held while stalled. They also check that protect commands without the high-voltage flag leave the protect bits alone, that a clear empties them and a set marks the named block, and that each query's acknowledge reflects the state as it stood before the query. Only the bench's scenarios can show the effects that span several commands. These are the address-to-block mapping across both pages, the reload from a second `prot_init` value, the one-cycle delay before `wr_ok` follows an update, and the fact that unknown opcodes leave the state untouched. The bench shows them through a reference model driven by random commands with random response stalls.

// File: rtl/spd_guard_pkg.sv
package spd_guard_pkg;
  typedef enum logic [2:0] {
    OP_PROT_SET = 3'd0,
    OP_PROT_CLR = 3'd1,
    OP_PROT_ASK = 3'd2,
    OP_PAGE_LO  = 3'd3,
    OP_PAGE_HI  = 3'd4,
    OP_PAGE_ASK = 3'd5
  } op_e;
endpackage

// File: rtl/spd_prot_bank.sv
module spd_prot_bank #(
  parameter int N_BLOCKS = 4,
  localparam int BLK_W = $clog2(N_BLOCKS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_BLOCKS-1:0] init_bits,
  input  logic                set_en,
  input  logic                clr_en,
  input  logic [BLK_W-1:0]    set_idx,
  output logic [N_BLOCKS-1:0] prot_q
);
  for (genvar g = 0; g < N_BLOCKS; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)
        prot_q[g] <= init_bits[g];
      else if (clr_en)
        prot_q[g] <= 1'b0;
      else if (set_en && set_idx == BLK_W'(g))
        prot_q[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/spd_page_bit.sv
module spd_page_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic lo_en,
  input  logic hi_en,
  output logic page_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     page_q <= 1'b0;
    else if (hi_en) page_q <= 1'b1;
    else if (lo_en) page_q <= 1'b0;
  end
endmodule

// File: rtl/spd_rsp_reg.sv
module spd_rsp_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic ack_in,
  input  logic rsp_ready,
  output logic rsp_valid,
  output logic rsp_ack,
  output logic slot_free
);
  assign slot_free = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ack   <= 1'b0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_ack   <= ack_in;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/spd_guard.sv
module spd_guard #(
  parameter int N_BLOCKS = 4,
  parameter int ADDR_W   = 8,
  localparam int BLK_W   = $clog2(N_BLOCKS),
  localparam int HALF_W  = BLK_W - 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_BLOCKS-1:0] prot_init,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [2:0]          cmd_op,
  input  logic [BLK_W-1:0]    cmd_blk,
  input  logic                cmd_hv,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic                rsp_ack,
  input  logic [ADDR_W-1:0]   wr_addr,
  output logic                wr_ok
);
  import spd_guard_pkg::*;

  logic [N_BLOCKS-1:0] prot_q;
  logic                page_q;
  logic                accept;
  logic                ack_d;
  logic                set_en, clr_en, lo_en, hi_en;
  logic [BLK_W-1:0]    wr_idx;
  op_e                 op;

  assign op     = op_e'(cmd_op);
  assign accept = cmd_valid && cmd_ready;

  always_comb begin
    ack_d  = 1'b0;
    set_en = 1'b0;
    clr_en = 1'b0;
    lo_en  = 1'b0;
    hi_en  = 1'b0;
    case (op)
      OP_PROT_SET: begin ack_d = cmd_hv; set_en = accept && cmd_hv; end
      OP_PROT_CLR: begin ack_d = cmd_hv; clr_en = accept && cmd_hv; end
      OP_PROT_ASK: ack_d = !prot_q[cmd_blk];
      OP_PAGE_LO:  begin ack_d = 1'b1; lo_en = accept; end
      OP_PAGE_HI:  begin ack_d = 1'b1; hi_en = accept; end
      OP_PAGE_ASK: ack_d = !page_q;
      default:     ack_d = 1'b0;
    endcase
  end

  spd_prot_bank #(.N_BLOCKS(N_BLOCKS)) u_bank (
    .clk(clk), .rst_n(rst_n), .init_bits(prot_init),
    .set_en(set_en), .clr_en(clr_en), .set_idx(cmd_blk), .prot_q(prot_q)
  );

  spd_page_bit u_page (
    .clk(clk), .rst_n(rst_n), .lo_en(lo_en), .hi_en(hi_en), .page_q(page_q)
  );

  spd_rsp_reg u_rsp (
    .clk(clk), .rst_n(rst_n), .load(accept), .ack_in(ack_d),
    .rsp_ready(rsp_ready), .rsp_valid(rsp_valid), .rsp_ack(rsp_ack),
    .slot_free(cmd_ready)
  );

  assign wr_idx = {page_q, wr_addr[ADDR_W-1 -: HALF_W]};
  assign wr_ok  = !prot_q[wr_idx];
endmodule

// File: rtl/spd_guard_chk.sv
module spd_guard_chk #(
  parameter int N_BLOCKS = 4,
  localparam int BLK_W = $clog2(N_BLOCKS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmd_valid,
  input logic                cmd_ready,
  input logic [2:0]          cmd_op,
  input logic [BLK_W-1:0]    cmd_blk,
  input logic                cmd_hv,
  input logic                rsp_valid,
  input logic                rsp_ready,
  input logic                rsp_ack,
  input logic [N_BLOCKS-1:0] prot_q,
  input logic                page_q
);
  logic acc;
  assign acc = cmd_valid && cmd_ready;

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_ack));

  assert_nohv_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !cmd_hv && (cmd_op == 3'd0 || cmd_op == 3'd1)
      |=> $stable(prot_q) && rsp_valid && !rsp_ack);

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_hv && cmd_op == 3'd1 |=> prot_q == '0 && rsp_ack);

  assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_hv && cmd_op == 3'd0 |=> prot_q[$past(cmd_blk)] && rsp_ack);

  assert_protask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_op == 3'd2 |=> rsp_ack == !$past(prot_q[cmd_blk]) && $stable(prot_q));

  assert_pageask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_op == 3'd5 |=> rsp_ack == !$past(page_q) && $stable(page_q));
endmodule

bind spd_guard spd_guard_chk #(.N_BLOCKS(N_BLOCKS)) u_chk (.*);

// File: tb/spd_guard_test.sv
module spd_guard_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] prot_init = 4'b0000;
  logic       cmd_valid = 1'b0, cmd_hv = 1'b0, rsp_ready = 1'b0;
  logic [2:0] cmd_op = 3'd7;
  logic [1:0] cmd_blk = 2'd0;
  logic [7:0] wr_addr = 8'h00;
  logic       cmd_ready, rsp_valid, rsp_ack, wr_ok;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [3:0] mprot;
  logic       mpage, m_rv, m_ra;
  string      m_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  spd_guard uut (
    .clk(clk), .rst_n(rst_n), .prot_init(prot_init),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_blk(cmd_blk), .cmd_hv(cmd_hv), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_ack(rsp_ack), .wr_addr(wr_addr), .wr_ok(wr_ok)
  );

  task automatic check(logic got, logic exp, string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0d exp %0d at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic string tag_of(logic [2:0] op, logic hv);
    case (op)
      3'd0: return hv ? "R3" : "R5";
      3'd1: return hv ? "R4" : "R5";
      3'd2: return "R6";
      3'd3, 3'd4: return "R7";
      3'd5: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic logic exp_ack(logic [2:0] op, logic [1:0] blk, logic hv);
    case (op)
      3'd0, 3'd1: return hv;
      3'd2: return !mprot[blk];
      3'd3, 3'd4: return 1'b1;
      3'd5: return !mpage;
      default: return 1'b0;
    endcase
  endfunction

  task automatic apply_model(logic [2:0] op, logic [1:0] blk, logic hv);
    case (op)
      3'd0: if (hv) mprot[blk] = 1'b1;
      3'd1: if (hv) mprot = 4'b0000;
      3'd3: mpage = 1'b0;
      3'd4: mpage = 1'b1;
      default: ;
    endcase
  endtask

  task automatic step(bit v, logic [2:0] op, logic [1:0] blk, bit hv, bit rr,
                      logic [7:0] a);
    bit acc;
    @(negedge clk);
    check(wr_ok, !mprot[{mpage, wr_addr[7]}], "R2/R11 wr_ok");
    check(rsp_valid, m_rv, "R10 rsp_valid");
    if (m_rv) check(rsp_ack, m_ra, m_tag);
    cmd_valid = v; cmd_op = op; cmd_blk = blk; cmd_hv = hv;
    rsp_ready = rr; wr_addr = a;
    #1;
    check(cmd_ready, !m_rv || rr, "R10 cmd_ready");
    acc = v && (!m_rv || rr);
    if (m_rv && rr) m_rv = 1'b0;
    if (acc) begin
      m_ra  = exp_ack(op, blk, hv);
      m_tag = tag_of(op, hv);
      m_rv  = 1'b1;
      apply_model(op, blk, hv);
    end
  endtask

  task automatic do_reset(logic [3:0] init);
    rst_n = 1'b0; prot_init = init; cmd_valid = 1'b0; rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mprot = init; mpage = 1'b0; m_rv = 1'b0; m_ra = 1'b0; m_tag = "R1";
    check(rsp_valid, 1'b0, "R1 no response after reset");
    wr_addr = 8'h00; #1;
    check(wr_ok, !init[0], "R1 block0 init");
    wr_addr = 8'h80; #1;
    check(wr_ok, !init[1], "R1 block1 init");
    step(1, 3'd5, 0, 0, 1, 8'h00);
    step(0, 3'd7, 0, 0, 1, 8'h00);
  endtask

  initial begin
    do_reset(4'b1010);
    // R2 mapping across both pages, R11 next-cycle visibility
    step(1, 3'd4, 0, 0, 1, 8'h10);
    step(1, 3'd2, 3, 0, 1, 8'h90);
    step(1, 3'd0, 2, 1, 1, 8'h05);
    step(1, 3'd2, 2, 0, 1, 8'h05);
    step(1, 3'd0, 0, 0, 1, 8'h7f); // R5 no hv
    step(1, 3'd1, 0, 0, 1, 8'hff); // R5 clear without hv
    step(1, 3'd6, 1, 1, 1, 8'h80); // R9
    step(1, 3'd7, 3, 1, 1, 8'h80); // R9
    step(1, 3'd1, 1, 1, 1, 8'h00); // R4
    step(1, 3'd5, 0, 0, 1, 8'h00); // R8 page 1
    step(1, 3'd3, 0, 1, 1, 8'h80); // R7
    // R10 stall: hold response, command must wait
    step(1, 3'd5, 0, 0, 0, 8'h00);
    step(1, 3'd4, 0, 0, 0, 8'h00);
    step(1, 3'd4, 0, 0, 0, 8'h00);
    step(1, 3'd4, 0, 0, 1, 8'h00);
    step(0, 3'd0, 0, 0, 1, 8'h00);
    void'($urandom(32'd4242));
    for (int i = 0; i < 3000; i++)
      step($urandom % 4 != 0, 3'($urandom), 2'($urandom), ($urandom % 3) != 0,
           ($urandom % 4) != 0, 8'($urandom));
    do_reset(4'b0101);
    for (int i = 0; i < 1000; i++)
      step($urandom % 4 != 0, 3'($urandom), 2'($urandom), ($urandom % 3) != 0,
           ($urandom % 4) != 0, 8'($urandom));
    step(0, 3'd7, 0, 0, 1, 8'h00);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired got 0 exp 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule